// File: doc/BRIEF.md
# Data Bit-Edge Sync Detector

This block locates the data-bit boundary of a tracked spread-spectrum signal. At the end of every primary-code integration, the tracking logic presents one sign bit on a strobe. That bit is the sign of the prompt in-phase sample. The block shifts each sign into a sliding window that spans two data bits. Once the window is full, every new shift triggers a comparison against a step template: one data bit of one sign followed by one data bit of the other. The comparison is made in both polarities. The number of disagreeing entries is measured against an error budget derived from a run-time tolerance.

When the window fits a template within budget, the block raises a sticky lock flag. It also reports which polarity matched and a symbol phase of zero, because a match can only happen on a true bit edge. From then on it ignores further signs until it is cleared. Downstream logic uses the flag to switch to full-symbol integrations and to start committing decoded bits.

Top module: `bit_edge_sync`

## Requirements
- R1: After reset, `found`, `pol_neg` and `phase` are all 0.
- R2: No lock can occur until 2×BLK_PER_BIT signs (40 by default) have been accepted since reset or clear, whatever their values.
- R3: The newest sign enters window bit 0. The positive template has ones in the BLK_PER_BIT low bits and zeros above them. A sign input of 1 denotes a non-negative prompt. A window within budget of this template locks with `pol_neg`=0.
- R4: A window within budget of the bitwise complement of the positive template locks with `pol_neg`=1.
- R5: The error budget is floor(`tol_pm` × 40 / 1000), with `tol_pm` in parts per thousand. At 25 the budget is 1 error, so 1 mismatch locks and 2 do not. At 50 the budget is 2 errors.
- R6: A change of `tol_pm` applies to the next comparison without any reset or clear.
- R7: Once `found` is 1, it stays 1 and `pol_neg` holds its value; further signs are ignored until clear or reset.
- R8: If both polarities are within budget, the one with fewer mismatches wins, and an equal count selects positive polarity.
- R9: A one-cycle `clr` returns the block to the unlocked, empty-window state; outputs read 0 on the cycle after.
- R10: A comparison happens only as a result of an accepted sign. `found` rises exactly two clock edges after the edge that sampled that sign, and never without one.
- R11: `phase` reads 0 while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear to unlocked, empty window |
| blk_valid | input | 1 | Strobe: one primary-code integration completed |
| blk_sign | input | 1 | Sign of prompt in-phase (1 = non-negative) |
| tol_pm | input | TOL_W | Mismatch tolerance in parts per thousand |
| found | output | 1 | Sticky lock flag |
| pol_neg | output | 1 | Locked polarity, 1 = negative |
| phase | output | PHASE_W | Symbol phase at lock (always 0) |

## Verification
The assertions assume that `blk_valid` is a single-cycle pulse per integration and that `clr` and `rst_n` are the only ways back to the unlocked state. The lock-timing property also assumes that `tol_pm` is stable between a strobe and the following edge. The stimulus changes the tolerance only during idle gaps of several cycles, pulses the strobe for one cycle at a time (sometimes back to back), and issues clear only after outstanding results have been compared. This keeps every sign an input the step-template rule can judge unambiguously.

// File: rtl/bes_pkg.sv
// Package: shared types for the bit-edge sync detector.
// Assumes nothing beyond SystemVerilog 2017.
package bes_pkg;

    // Locked polarity encoding as reported on pol_neg.
    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } pol_e;

endpackage

// File: rtl/bes_window.sv
// Module: bes_window
// Sliding window of block signs plus a saturating fill counter.
// The newest sign enters bit 0. Shifts only when shift_en is high.
// Assumes shift_en is already gated by the lock state.
module bes_window #(
    parameter int WIN   = 40,
    parameter int CNT_W = $clog2(WIN + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           shift_en,
    input  logic           sgn,
    output logic [WIN-1:0] win,
    output logic           full
);

    logic [CNT_W-1:0] fill_q;

    // Shift the new sign in and count the window fill, saturating at WIN.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win    <= '0;
            fill_q <= '0;
        end else if (shift_en) begin
            win <= {win[WIN-2:0], sgn};
            if (fill_q != CNT_W'(WIN)) begin
                fill_q <= fill_q + CNT_W'(1);
            end
        end
    end

    // Window is full once WIN signs have been accepted.
    always_comb begin
        full = (fill_q == CNT_W'(WIN));
    end

endmodule

// File: rtl/bes_errcount.sv
// Module: bes_errcount
// Hamming distance between the window and a step template:
// HALF ones in the low bits, zeros above, optionally inverted.
// Purely combinational; assumes WIN = 2*HALF.
module bes_errcount #(
    parameter int HALF   = 20,
    parameter bit INVERT = 1'b0,
    parameter int WIN    = 2 * HALF,
    parameter int CNT_W  = $clog2(WIN + 1)
) (
    input  logic [WIN-1:0] win,
    output logic [CNT_W-1:0] errs
);

    logic [WIN-1:0] tmpl;
    logic [WIN-1:0] diff;

    // Build the step template for the chosen polarity.
    always_comb begin
        for (int i = 0; i < WIN; i++) begin
            tmpl[i] = (i < HALF) ^ INVERT;
        end
    end

    // Count mismatching entries.
    always_comb begin
        diff = win ^ tmpl;
        errs = '0;
        for (int i = 0; i < WIN; i++) begin
            errs = errs + CNT_W'(diff[i]);
        end
    end

endmodule

// File: rtl/bes_lock.sv
// Module: bes_lock
// Converts the tolerance to an error budget, picks the better polarity
// and holds the sticky lock. Evaluates one cycle after each accepted sign.
// Assumes the window is updated on the same edge that sets eval pending.
module bes_lock #(
    parameter int WIN       = 40,
    parameter int TOL_W     = 10,
    parameter int TOL_SCALE = 1000,
    parameter int CNT_W     = $clog2(WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             accepted,
    input  logic             full,
    input  logic [TOL_W-1:0] tol,
    input  logic [CNT_W-1:0] errs_pos,
    input  logic [CNT_W-1:0] errs_neg,
    output logic             found,
    output bes_pkg::pol_e    pol
);

    localparam int PROD_W = TOL_W + CNT_W + 1;

    logic              pend_q;
    logic [PROD_W-1:0] budget;
    logic              pos_ok;
    logic              neg_ok;
    logic              hit;
    bes_pkg::pol_e     pick;

    // Budget = floor(tol * WIN / TOL_SCALE).
    always_comb begin
        budget = (PROD_W'(tol) * PROD_W'(WIN)) / PROD_W'(TOL_SCALE);
    end

    // Choose polarity: within budget, fewer errors, ties to positive.
    always_comb begin
        pos_ok = (PROD_W'(errs_pos) <= budget);
        neg_ok = (PROD_W'(errs_neg) <= budget);
        hit    = pos_ok || neg_ok;
        if (neg_ok && (!pos_ok || (errs_neg < errs_pos))) begin
            pick = bes_pkg::POL_NEG;
        end else begin
            pick = bes_pkg::POL_POS;
        end
    end

    // Track pending evaluation and latch the lock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend_q <= 1'b0;
            found  <= 1'b0;
            pol    <= bes_pkg::POL_POS;
        end else begin
            pend_q <= accepted;
            if (pend_q && full && !found && hit) begin
                found <= 1'b1;
                pol   <= pick;
            end
        end
    end

endmodule

// File: rtl/bit_edge_sync.sv
// Module: bit_edge_sync (top)
// Data bit-edge sync detector: window of block signs, two-polarity step
// template match with tolerance-derived error budget, sticky lock.
// Assumes blk_valid pulses once per primary-code integration.
module bit_edge_sync #(
    parameter int BLK_PER_BIT = 20,
    parameter int TOL_W       = 10,
    parameter int TOL_SCALE   = 1000,
    parameter int PHASE_W     = $clog2(BLK_PER_BIT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               blk_valid,
    input  logic               blk_sign,
    input  logic [TOL_W-1:0]   tol_pm,
    output logic               found,
    output logic               pol_neg,
    output logic [PHASE_W-1:0] phase
);

    localparam int WIN   = 2 * BLK_PER_BIT;
    localparam int CNT_W = $clog2(WIN + 1);

    logic             accepted;
    logic [WIN-1:0]   win;
    logic             full;
    logic [CNT_W-1:0] errs [2];
    bes_pkg::pol_e    pol;

    // Signs are taken only while unlocked.
    always_comb begin
        accepted = blk_valid && !found;
    end

    bes_window #(.WIN(WIN), .CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (accepted),
        .sgn      (blk_sign),
        .win      (win),
        .full     (full)
    );

    // One distance unit per polarity: index 0 positive, 1 negative.
    for (genvar p = 0; p < 2; p++) begin : g_pol
        bes_errcount #(
            .HALF   (BLK_PER_BIT),
            .INVERT (p[0]),
            .WIN    (WIN),
            .CNT_W  (CNT_W)
        ) u_err (
            .win  (win),
            .errs (errs[p])
        );
    end

    bes_lock #(
        .WIN       (WIN),
        .TOL_W     (TOL_W),
        .TOL_SCALE (TOL_SCALE),
        .CNT_W     (CNT_W)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .accepted (accepted),
        .full     (full),
        .tol      (tol_pm),
        .errs_pos (errs[0]),
        .errs_neg (errs[1]),
        .found    (found),
        .pol      (pol)
    );

    // Outputs: polarity flag and a lock phase that is always a bit edge.
    always_comb begin
        pol_neg = (pol == bes_pkg::POL_NEG);
        phase   = '0;
    end

endmodule

// File: rtl/bit_edge_sync_chk.sv
// Module: bit_edge_sync_chk
// Checker bound to bit_edge_sync. Counts accepted signs independently and
// checks lock timing, stickiness and clear behaviour.
module bit_edge_sync_chk #(
    parameter int WIN = 40
) (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic blk_valid,
    input logic found,
    input logic pol_neg
);

    localparam int CNT_W = $clog2(WIN + 1);

    logic [CNT_W-1:0] seen_q;

    // Count accepted signs since reset or clear, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen_q <= '0;
        end else if (blk_valid && !found && seen_q != CNT_W'(WIN)) begin
            seen_q <= seen_q + CNT_W'(1);
        end
    end

    a_r1_reset_unlocked: assert property (@(posedge clk)
        !rst_n |=> (!found && !pol_neg));

    a_r2_no_early_lock: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(found) |-> (seen_q == CNT_W'(WIN)));

    a_r7_found_sticky: assert property (@(posedge clk) disable iff (!rst_n || clr)
        found |=> found);

    a_r7_pol_held: assert property (@(posedge clk) disable iff (!rst_n || clr)
        found |=> $stable(pol_neg));

    a_r9_clear_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!found && !pol_neg));

    a_r10_lock_follows_sign: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(found) |-> $past(blk_valid, 2));

endmodule

bind bit_edge_sync bit_edge_sync_chk #(.WIN(WIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .blk_valid (blk_valid),
    .found     (found),
    .pol_neg   (pol_neg)
);

// File: tb/tb_bit_edge_sync.sv
// Scoreboard bench: driver pushes expected lock state per sign, monitor compares.
module tb_bit_edge_sync;

    localparam int HALF = 20;
    localparam int WIN  = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       blk_valid = 1'b0;
    logic       blk_sign = 1'b0;
    logic [9:0] tol_pm = 10'd25;
    logic       found;
    logic       pol_neg;
    logic [4:0] phase;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int    due;
        bit    e_found;
        bit    e_neg;
        string tag;
    } exp_t;

    exp_t sbq[$];

    // Reference model state.
    logic [WIN-1:0] m_win;
    int             m_fill;
    bit             m_found;
    bit             m_neg;
    string          cur_tag;

    bit_edge_sync dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .blk_valid (blk_valid),
        .blk_sign  (blk_sign),
        .tol_pm    (tol_pm),
        .found     (found),
        .pol_neg   (pol_neg),
        .phase     (phase)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_win   = '0;
        m_fill  = 0;
        m_found = 1'b0;
        m_neg   = 1'b0;
    endtask

    // Driver: present one sign, update the model, push the expectation.
    task automatic send(input bit s);
        int pe;
        int ne;
        int bud;
        exp_t e;
        @(negedge clk);
        blk_valid = 1'b1;
        blk_sign  = s;
        @(posedge clk);
        #1;
        if (!m_found) begin
            m_win = {m_win[WIN-2:0], s};
            if (m_fill < WIN) m_fill++;
            if (m_fill == WIN) begin
                pe  = $countones(m_win ^ {{HALF{1'b0}}, {HALF{1'b1}}});
                ne  = WIN - pe;
                bud = (int'(tol_pm) * WIN) / 1000;
                if (pe <= bud || ne <= bud) begin
                    m_found = 1'b1;
                    m_neg   = (ne <= bud) && (pe > bud || ne < pe);
                end
            end
        end
        e.due     = cyc + 1;
        e.e_found = m_found;
        e.e_neg   = m_neg;
        e.tag     = cur_tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        blk_valid = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    task automatic sendn(input bit s, input int n);
        for (int i = 0; i < n; i++) send(s);
    endtask

    // Monitor: compare due expectations away from the active edge.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            chk(found == e.e_found, {e.tag, " found"}, found, e.e_found);
            chk(pol_neg == e.e_neg, {e.tag, " pol_neg"}, pol_neg, e.e_neg);
            if (found) chk(phase == 0, "R11 phase", phase, 0);
        end
    end

    task automatic do_clear();
        idle(3);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_reset();
        chk(!found && !pol_neg, "R9 clear", {found, pol_neg}, 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!found && !pol_neg && phase == 0, "R1 reset", {found, pol_neg}, 0);
        rst_n = 1'b1;

        // R2: 20 ones would fit the low half of an empty window; must not lock.
        cur_tag = "R2 early";
        sendn(1'b1, 20);
        do_clear();

        // R3: positive step, exact.
        cur_tag = "R3 pos";
        sendn(1'b0, 20);
        sendn(1'b1, 20);
        // R7: further signs ignored after lock.
        cur_tag = "R7 ignore";
        sendn(1'b0, 25);
        idle(3);
        do_clear();

        // R4: negative step, back-to-back strobes.
        cur_tag = "R4 neg";
        sendn(1'b1, 20);
        sendn(1'b0, 20);
        do_clear();

        // R5: one mismatch accepted at 25 per mille.
        cur_tag = "R5 one err";
        sendn(1'b0, 7);
        send(1'b1);
        sendn(1'b0, 12);
        sendn(1'b1, 20);
        do_clear();

        // R5/R6/R10: two mismatches rejected at 25, then accepted at 50.
        cur_tag = "R5 two err";
        send(1'b1);
        sendn(1'b0, 19);
        sendn(1'b1, 10);
        send(1'b0);
        sendn(1'b1, 9);
        idle(3);
        tol_pm = 10'd50;
        idle(4);
        chk(!found, "R10 no eval without sign", found, 0);
        cur_tag = "R6 tol change";
        send(1'b1);
        idle(3);
        do_clear();

        // R8: tie with wide budget selects positive.
        tol_pm  = 10'd500;
        cur_tag = "R8 tie";
        sendn(1'b0, 40);
        do_clear();

        // R8: fewer errors wins (neg has 10, pos has 30).
        tol_pm  = 10'd1000;
        cur_tag = "R8 fewer";
        sendn(1'b1, 30);
        sendn(1'b0, 10);
        idle(3);
        tol_pm = 10'd25;
        do_clear();

        // Random sweep against the model.
        cur_tag = "R3 R4 R5 sweep";
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 60; i++) send(1'($urandom_range(0, 1)));
            for (int i = 0; i < HALF; i++) send(1'b1);
            for (int i = 0; i < HALF; i++) send(1'b0);
            do_clear();
        end

        idle(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule